// File: doc/BRIEF.md
# Dual-Lane Serial Result Readout

This block is the serial read port of an eight-channel sampling converter. A bank of eight 16-bit result registers captures the converter's results on every falling edge of the converter's busy indication. A host then pulls those results out over a serial link: it lowers an active-low chip select and toggles a serial clock, and the block shifts the results out most-significant bit first on two data lines, lane A and lane B. The host sees data change after its serial-clock rising edges and samples on falling edges.

Lane A starts with channel 1 and lane B with channel 5. Each lane keeps counting through all eight channels, so a host that wires only one data line still gets every result, with 128 clocks instead of 64. A first-channel indicator goes high while channel 1 sits on lane A, so a host reading only lane B sees it during channel 5. The host serial clock, chip select and busy are asynchronous to the block's faster system clock. They are synchronised and edge-detected inside, and every output is registered. The data lines and the indicator share one drive enable, which a pad ring uses for high impedance.

Top module: `serial_result_port`

## Requirements
- R1: `out_en` is 0 after reset and while chip select is high. It is 1 while chip select is low.
- R2: A chip-select fall places the MSB (bit 15) of each lane's current channel on `dout_a` / `dout_b` before any serial-clock edge.
- R3: Each serial-clock rising edge under a low chip select shifts out the next lower bit. A word is 16 bits, MSB first.
- R4: Channel k (1 to 8) is `res_in[(k-1)*16 +: 16]`. Lane A gives channels 1,2,...,8 and then 1 again. Lane B gives 5,6,7,8,1,2,3,4 and then 5 again. A 64-clock frame with both lanes delivers all eight results, and a 128-clock frame on one lane does as well.
- R5: The bank and both lane pointers change only on a busy falling edge. At that edge the bank takes `res_in` and lane A is set to channel 1, lane B to channel 5. `res_in` changes without that edge have no effect.
- R6: Raising chip select between complete 16-bit words keeps the channel position. The next frame continues with the following channel.
- R7: A chip-select rise before the 16th rising edge of a word abandons the word. The next frame restarts the same channel at its MSB.
- R8: `first_ch` is 0 while chip select is high. A chip-select fall sets it to 1 if lane A is at channel 1, and it returns to 0 after the 16th serial-clock falling edge of that word.
- R9: `first_ch` also rises when lane A wraps back to channel 1 within a frame. It stays 0 during the word where lane B carries channel 1.
- R10: With chip select low and the serial clock still, the data lines hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock, idles high |
| cs_n | input | 1 | Host chip select, active low |
| busy | input | 1 | Converter busy; falling edge loads the result bank |
| res_in | input | 128 | Eight 16-bit results, channel 1 in the low word |
| dout_a | output | 1 | Lane A serial data |
| dout_b | output | 1 | Lane B serial data |
| first_ch | output | 1 | High while channel 1 is on lane A |
| out_en | output | 1 | Drive enable for dout_a, dout_b and first_ch |

## Verification
Three framings are exercised, each over a full cycle of channels with arithmetically generated word values plus a corner set (0x8000, 0x0001, 0xFFFF, 0x0000, alternating patterns) that exposes bit-order and shift-off-by-one faults. The framings are a 64-clock dual-lane frame, a 144-clock single frame that runs lane A past its wrap, and per-word chip-select pulsing. Comparing them separates position loss at chip-select rise from errors in pointer wrap and lane offset. Abandoned words at 7 and at 15 bits distinguish a correct advance at the 16th edge from an early one. Input changes without a busy edge, and a busy edge in the middle of a sequence, separate bank capture from pointer reset.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int DATA_W      = 16;
  localparam int NUM_CH      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_LANES   = 2;

  // Indices of the asynchronous host inputs inside the synchroniser vector
  localparam int SIG_SCLK = 0;
  localparam int SIG_CS   = 1;
  localparam int SIG_BUSY = 2;
  localparam int NUM_SIG  = 3;
endpackage

// File: rtl/rdo_edge_sync.sv
module rdo_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/rdo_lane.sv
module rdo_lane #(
  parameter int W     = 16,
  parameter int N     = 8,
  parameter int START = 0,
  localparam int PTR_W = $clog2(N),
  localparam int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     bank_i [N],
  input  logic             ld_i,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             rise_i,
  output logic             bit_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     sh_q, sh_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_nx;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             word_end;
  logic             cur_msb;

  assign ptr_nx   = (ptr_q == PTR_W'(N-1)) ? '0 : ptr_q + PTR_W'(1);
  assign word_end = (cnt_q == CNT_W'(W-1));
  assign cur_msb  = bank_i[ptr_q][W-1];

  always_comb begin
    sh_d  = sh_q;
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (ld_i) begin
      ptr_d = PTR_W'(START);
      cnt_d = '0;
    end else if (cs_fall_i) begin
      sh_d  = bank_i[ptr_q];
      cnt_d = '0;
    end else if (cs_rise_i) begin
      cnt_d = '0;
    end else if (rise_i) begin
      if (word_end) begin
        ptr_d = ptr_nx;
        sh_d  = bank_i[ptr_nx];
        cnt_d = '0;
      end else begin
        sh_d  = {sh_q[W-2:0], 1'b0};
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      ptr_q <= PTR_W'(START);
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_o = sh_q[W-1];
  assign ptr_o = ptr_q;
  assign cnt_o = cnt_q;

  // R2: chip-select fall presents the MSB of the current channel
  a_r2_msb_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_i && !ld_i |=> bit_o == $past(cur_msb));
  // R6, R7: the pointer moves only at a word end or at a busy fall
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i && !(rise_i && word_end) |=> $stable(ptr_q));
  // R5: busy fall returns the lane to its start channel
  a_r5_ptr_start: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> ptr_q == PTR_W'(START));
  // R7: an abandoned word restarts its bit count
  a_r7_abort_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_i && !ld_i |=> cnt_q == '0);
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
  import rdo_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int N      = NUM_CH,
  parameter int STAGES = SYNC_STAGES,
  localparam int PTR_W = $clog2(N),
  localparam int CNT_W = $clog2(W),
  localparam int HALF  = N / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         busy,
  input  logic [N*W-1:0] res_in,
  output logic         dout_a,
  output logic         dout_b,
  output logic         first_ch,
  output logic         out_en
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // Synchronise and edge-detect the host inputs
  localparam logic [NUM_SIG-1:0] IDLE = 3'b011;
  logic [NUM_SIG-1:0] raw, lvl, rise, fall;
  assign raw = {busy, cs_n, sclk};

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sync
    rdo_edge_sync #(.STAGES(STAGES), .RST_VAL(IDLE[s])) u_sync (
      .clk(clk), .rst_n(rst_int_n), .d_i(raw[s]),
      .lvl_o(lvl[s]), .rise_o(rise[s]), .fall_o(fall[s]));
  end

  logic ld, cs_fall, cs_rise, sel, sck_rise, sck_fall;
  assign ld       = fall[SIG_BUSY];
  assign cs_fall  = fall[SIG_CS];
  assign cs_rise  = rise[SIG_CS];
  assign sel      = ~lvl[SIG_CS];
  assign sck_rise = rise[SIG_SCLK] & sel;
  assign sck_fall = fall[SIG_SCLK] & sel;

  // Result bank, captured on busy fall only
  logic [W-1:0] bank_q [N];
  logic [W-1:0] bank_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) bank_d[i] = ld ? res_in[i*W +: W] : bank_q[i];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < N; i++) bank_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) bank_q[i] <= bank_d[i];
    end
  end

  // Two lanes, offset by half the channel set
  logic             bit_l [NUM_LANES];
  logic [PTR_W-1:0] ptr_l [NUM_LANES];
  logic [CNT_W-1:0] cnt_l [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    rdo_lane #(.W(W), .N(N), .START(g * HALF)) u_lane (
      .clk(clk), .rst_n(rst_int_n), .bank_i(bank_q),
      .ld_i(ld), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .rise_i(sck_rise),
      .bit_o(bit_l[g]), .ptr_o(ptr_l[g]), .cnt_o(cnt_l[g]));
  end

  // Drive enable and first-channel flag (follows lane A only)
  logic oe_q, oe_d, flag_q, flag_d;
  logic a_last_bit, a_wraps;
  assign a_last_bit = (cnt_l[0] == CNT_W'(W-1));
  assign a_wraps    = sck_rise && a_last_bit && (ptr_l[0] == PTR_W'(N-1));

  always_comb begin
    oe_d   = oe_q;
    flag_d = flag_q;
    if (cs_fall) begin
      oe_d   = 1'b1;
      flag_d = (ptr_l[0] == '0) && !ld;
    end else if (cs_rise || ld) begin
      oe_d   = cs_rise ? 1'b0 : oe_q;
      flag_d = 1'b0;
    end else if (sck_fall && a_last_bit) begin
      flag_d = 1'b0;
    end else if (a_wraps) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      oe_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      oe_q   <= oe_d;
      flag_q <= flag_d;
    end
  end

  assign dout_a   = bit_l[0];
  assign dout_b   = bit_l[1];
  assign first_ch = flag_q;
  assign out_en   = oe_q;

  // R1: drive enable follows chip select edges
  a_r1_enable_on: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_fall |=> out_en);
  a_r1_enable_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_rise |=> !out_en);
  // R4: lane B always sits half a channel set ahead of lane A
  a_r4_lane_offset: assert property (@(posedge clk) disable iff (!rst_int_n)
    ptr_l[1] == PTR_W'((int'(ptr_l[0]) + HALF) % N));
  // R9: the flag is only ever high while lane A carries channel 1
  a_r9_flag_lane_a: assert property (@(posedge clk) disable iff (!rst_int_n)
    first_ch |-> ptr_l[0] == '0);
  // R8: the flag is never high while the outputs float
  a_r8_flag_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !out_en |-> !first_ch);
endmodule

// File: tb/serial_result_port_test.sv
module serial_result_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int N = 8;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic busy = 1'b0;
  logic [N*W-1:0] res_in = '0;
  logic dout_a, dout_b, first_ch, out_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_result_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .busy(busy),
    .res_in(res_in), .dout_a(dout_a), .dout_b(dout_b),
    .first_ch(first_ch), .out_en(out_en));

  function automatic logic [W-1:0] val(input int set, input int ch);
    if (set == 0) begin
      case (ch)
        1: return 16'h8000;  2: return 16'h0001;
        3: return 16'hFFFF;  4: return 16'h0000;
        5: return 16'h7FFF;  6: return 16'hAAAA;
        7: return 16'h5555;  default: return 16'h0F0F;
      endcase
    end
    return W'((set * 40503 + ch * 9973 + 4660) ^ (ch << 12));
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_set(input int s);
    @(negedge clk);
    for (int ch = 1; ch <= N; ch++) res_in[(ch-1)*W +: W] = val(s, ch);
    busy = 1'b1; idle(H);
    busy = 1'b0; idle(H);
  endtask

  task automatic cs_down();
    @(negedge clk); cs_n = 1'b0; idle(8);
  endtask

  task automatic cs_up();
    @(negedge clk); cs_n = 1'b1; idle(8);
  endtask

  // Clocks nbits serial periods; samples at each falling edge
  task automatic read_bits(input int nbits, output logic [W-1:0] a, output logic [W-1:0] b,
                           output logic fl_first, output logic fl_after);
    a = '0; b = '0; fl_first = 1'b0; fl_after = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      a = {a[W-2:0], dout_a};
      b = {b[W-2:0], dout_b};
      if (i == 0) fl_first = first_ch;
      sclk = 1'b0; idle(H);
      if (i == W-1) fl_after = first_ch;
      sclk = 1'b1; idle(H);
    end
  endtask

  logic [W-1:0] ra, rb, hold;
  logic ff, fa;

  initial begin
    idle(4); rst_n = 1'b1; idle(6);
    check("R1 reset out_en", W'(out_en), 16'd0);
    check("R8 reset first_ch", W'(first_ch), 16'd0);

    // Dual-lane 64-clock frame
    load_set(0);
    cs_down();
    check("R1 out_en low select", W'(out_en), 16'd1);
    check("R2 msb lane A", W'(dout_a), W'(val(0,1) >> (W-1)));
    check("R2 msb lane B", W'(dout_b), W'(val(0,5) >> (W-1)));
    check("R8 flag at select", W'(first_ch), 16'd1);
    for (int i = 0; i < 4; i++) begin
      read_bits(W, ra, rb, ff, fa);
      check($sformatf("R3 R4 dual A word %0d", i), ra, val(0, i+1));
      check($sformatf("R3 R4 dual B word %0d", i), rb, val(0, i+5));
      check($sformatf("R8 flag first w%0d", i), W'(ff), W'(i == 0));
      check($sformatf("R8 flag after w%0d", i), W'(fa), 16'd0);
    end
    cs_up();
    check("R1 out_en after deselect", W'(out_en), 16'd0);
    check("R8 flag after deselect", W'(first_ch), 16'd0);

    // Single 144-clock frame: lane A wraps, lane B carries 5..8,1..4
    load_set(1);
    cs_down();
    for (int i = 0; i < 9; i++) begin
      read_bits(W, ra, rb, ff, fa);
      check($sformatf("R4 long A word %0d", i), ra, val(1, (i % 8) + 1));
      check($sformatf("R4 long B word %0d", i), rb, val(1, ((i + 4) % 8) + 1));
      check($sformatf("R9 flag word %0d", i), W'(ff), W'(i % 8 == 0));
    end
    cs_up();

    // Per-word framing keeps position
    load_set(2);
    for (int i = 0; i < 8; i++) begin
      cs_down();
      read_bits(W, ra, rb, ff, fa);
      check($sformatf("R6 framed A word %0d", i), ra, val(2, i + 1));
      check($sformatf("R6 framed B word %0d", i), rb, val(2, ((i + 4) % 8) + 1));
      cs_up();
      check($sformatf("R1 framed idle %0d", i), W'(out_en), 16'd0);
    end

    // Abandoned words
    load_set(3);
    cs_down();
    read_bits(7, ra, rb, ff, fa);
    cs_up();
    cs_down();
    check("R7 R8 flag after abort", W'(first_ch), 16'd1);
    read_bits(W, ra, rb, ff, fa);
    check("R7 restart A after 7 bits", ra, val(3, 1));
    check("R7 restart B after 7 bits", rb, val(3, 5));
    cs_up();
    cs_down();
    read_bits(W-1, ra, rb, ff, fa);
    cs_up();
    cs_down();
    read_bits(W, ra, rb, ff, fa);
    check("R7 restart A after 15 bits", ra, val(3, 2));
    cs_up();

    // Input change without busy edge is ignored
    @(negedge clk);
    for (int ch = 1; ch <= N; ch++) res_in[(ch-1)*W +: W] = val(4, ch);
    idle(8);
    cs_down();
    read_bits(W, ra, rb, ff, fa);
    check("R5 no capture A", ra, val(3, 3));
    check("R5 no capture B", rb, val(3, 7));
    cs_up();

    // Busy edge mid-sequence captures and rewinds
    load_set(4);
    cs_down();
    check("R5 R8 flag after rewind", W'(first_ch), 16'd1);
    read_bits(W, ra, rb, ff, fa);
    check("R5 rewind A", ra, val(4, 1));
    check("R5 rewind B", rb, val(4, 5));
    @(negedge clk); hold = {14'd0, dout_b, dout_a};
    idle(40);
    check("R10 hold without sclk", {14'd0, dout_b, dout_a}, hold);
    cs_up();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule